// File: doc/BRIEF.md
# Host Bridge Register Window Controller

This block is the configuration front end of a service-interface host bridge. It has two 64-bit register ports. The sideband configuration port does one job: it programs the base-address register that places a 1 MiB MMIO window in the system address map. The main MMIO port decodes accesses that fall inside that window. It holds the bridge's control registers: interrupt control, the event-page base, the notification address and the vector-table offset.

The block drives out the MMIO window base and its enable. It also drives the base and enable of a second 64 KiB window that holds the per-source event-state pages. When software sets the reset bit in interrupt control, the block emits a one-cycle pulse that resets the interrupt sources. Every access on either port is a single 64-bit big-endian word. Bit n in the register descriptions below means value bit 63-n, except where a value bit is named directly. Each accepted request gets exactly one response, one cycle later.

Top module: `bridge_regwin`

## Requirements
- R1: After reset, the MMIO window is enabled at the configured default base, the event-page window is disabled, and all control registers read as zero.
- R2: Any request whose length is not 8 bytes returns a response flagged bad, with data all ones, and changes no register or output.
- R3: A sideband write to offset 0x0 loads the BAR. Value bit 0 is the window enable, and the window base is the value with bit 0 cleared. Sideband writes to any other offset have no effect. Every sideband read returns all ones.
- R4: An MMIO request gets a response and takes effect only while the window is enabled and its address lies in the 1 MiB range starting at the window base. Any other MMIO request gets no response and has no effect.
- R5: MMIO offsets 0x58, 0x68 and 0x70 store written values and read them back. Offsets 0x20 and 0x28 accept writes with no effect and read as zero. A good write response carries data zero.
- R6: An MMIO read of an undecoded offset returns all ones. An MMIO write to an undecoded offset is dropped, and the error flag pulses high for the one cycle after the write.
- R7: A write to offset 0x58 with value bit 62 set makes the source reset output pulse high for the one cycle after the write. The written value is still stored. A write with value bit 62 clear gives no pulse.
- R8: At offset 0x60, value bit 0 is a valid flag. The event-page window opens only when the stored flag goes from 0 to 1, at the written value with bit 0 cleared. While the flag stays 1, rewrites store the new value but leave the window base unchanged. The window closes only when the flag goes from 1 to 0.
- R9: Rewriting the BAR always drops the old window. The MMIO window is present afterwards only if the new value has bit 0 set, and only at the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_valid | input | 1 | Sideband request strobe |
| sb_write | input | 1 | Sideband request is a write |
| sb_addr | input | 8 | Sideband byte offset |
| sb_len | input | 4 | Sideband access length in bytes |
| sb_wdata | input | 64 | Sideband write data |
| sb_rsp_valid | output | 1 | Sideband response strobe |
| sb_rsp_bad | output | 1 | Sideband request rejected for length |
| sb_rsp_data | output | 64 | Sideband response data |
| mm_valid | input | 1 | MMIO request strobe |
| mm_write | input | 1 | MMIO request is a write |
| mm_addr | input | AW | MMIO absolute byte address |
| mm_len | input | 4 | MMIO access length in bytes |
| mm_wdata | input | 64 | MMIO write data |
| mm_rsp_valid | output | 1 | MMIO response strobe |
| mm_rsp_bad | output | 1 | MMIO request rejected for length |
| mm_rsp_data | output | 64 | MMIO response data |
| win_en | output | 1 | MMIO window enable |
| win_base | output | AW | MMIO window base address |
| esb_en | output | 1 | Event-page window enable |
| esb_base | output | AW | Event-page window base address |
| src_reset | output | 1 | One-cycle interrupt source reset pulse |
| undec_err | output | 1 | One-cycle undecoded MMIO write flag |

## Verification
Some properties are checked by assertions on every cycle. The BAR holds unless an accepted sideband write arrives. The event-page enable always follows the stored valid flag, and its base stays frozen while the window is open. A source reset pulse always coincides with a stored control value that has the reset bit set. A bad response never comes with anything but all-ones data. Other behaviour shows only through the bench's scenarios. These cover the exact read-back values and the undecoded and rejected-length cases. They also cover the absence of a response for addresses outside the window or after it moves, and the event-page base staying unchanged across a rewrite that keeps the valid flag set.

// File: rtl/bridge_regwin_pkg.sv
// Shared constants and types for the bridge register window controller.
// Assumes 64-bit data; offsets are byte offsets inside the MMIO window.
package bridge_regwin_pkg;
    localparam int DW = 64;
    localparam logic [DW-1:0] ALL_ONES = '1;
    localparam int OFS_SPA       = 'h20;
    localparam int OFS_SPB       = 'h28;
    localparam int OFS_INTCTL    = 'h58;
    localparam int OFS_ESB       = 'h60;
    localparam int OFS_NOTIFY    = 'h68;
    localparam int OFS_VECOFS    = 'h70;
    localparam int INTRST_BIT    = 62;   // MSB-first bit 1
    localparam int EN_BIT        = 0;    // enable / valid flag position
    localparam int WORD_BYTES    = 8;

    typedef struct packed {
        logic          valid;
        logic          bad;
        logic [DW-1:0] data;
    } rsp_t;
endpackage

// File: rtl/bridge_sb_port.sv
// Sideband configuration port: owns the BAR register only.
// Assumes one request per cycle; responds one cycle later; reads give all ones.
module bridge_sb_port
    import bridge_regwin_pkg::*;
#(
    parameter int             OFS_W      = 8,
    parameter logic [DW-1:0]  DEF_BASE   = 64'h0000_0030_2030_0000,
    parameter int             BAR_OFS    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_addr,
    input  logic [3:0]       req_len,
    input  logic [DW-1:0]    req_wdata,
    output rsp_t             rsp,
    output logic [DW-1:0]    bar
);
    logic len_ok, bar_wr;
    assign len_ok = (req_len == 4'(WORD_BYTES));
    assign bar_wr = req_valid && req_write && len_ok && (req_addr == OFS_W'(BAR_OFS));

    // BAR register: reset to default base with enable set, else sideband load
    always_ff @(posedge clk) begin
        if (!rst_n)      bar <= DEF_BASE | (DW'(1) << EN_BIT);
        else if (bar_wr) bar <= req_wdata;
    end

    // Response register: one response per request, one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) rsp <= '0;
        else begin
            rsp.valid <= req_valid;
            rsp.bad   <= req_valid && !len_ok;
            rsp.data  <= (!len_ok || !req_write) ? ALL_ONES : '0;
        end
    end

    p_bar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bar_wr) |-> $stable(bar));
    p_bad_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp.bad |-> rsp.valid && rsp.data == ALL_ONES);
endmodule

// File: rtl/bridge_mmio_regs.sv
// MMIO port: decodes accesses inside the 1 MiB window and holds the control
// registers. Assumes the BAR enable is value bit 0 and requests are single words.
module bridge_mmio_regs
    import bridge_regwin_pkg::*;
#(
    parameter int AW     = 48,
    parameter int WIN_SH = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bar_base,
    input  logic          bar_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_len,
    input  logic [DW-1:0] req_wdata,
    output rsp_t          rsp,
    output logic          undec_err,
    output logic          src_reset,
    output logic [DW-1:0] esb_reg,
    output logic          esb_wr
);
    logic [DW-1:0]     intctl_q, notify_q, vecofs_q, rd_val;
    logic [WIN_SH-1:0] ofs;
    logic              hit, len_ok, decoded, wr_ok;

    assign ofs    = req_addr[WIN_SH-1:0];
    assign hit    = req_valid && bar_en && (req_addr[AW-1:WIN_SH] == bar_base[AW-1:WIN_SH]);
    assign len_ok = (req_len == 4'(WORD_BYTES));
    assign wr_ok  = hit && len_ok && req_write;
    assign esb_wr = wr_ok && (ofs == WIN_SH'(OFS_ESB));

    // Read mux and decode flag for the window offset
    always_comb begin
        decoded = 1'b1;
        rd_val  = '0;
        case (ofs)
            WIN_SH'(OFS_SPA), WIN_SH'(OFS_SPB): rd_val = '0;
            WIN_SH'(OFS_INTCTL): rd_val = intctl_q;
            WIN_SH'(OFS_ESB):    rd_val = esb_reg;
            WIN_SH'(OFS_NOTIFY): rd_val = notify_q;
            WIN_SH'(OFS_VECOFS): rd_val = vecofs_q;
            default: begin decoded = 1'b0; rd_val = ALL_ONES; end
        endcase
    end

    // Control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intctl_q <= '0; esb_reg <= '0; notify_q <= '0; vecofs_q <= '0;
        end else if (wr_ok) begin
            case (ofs)
                WIN_SH'(OFS_INTCTL): intctl_q <= req_wdata;
                WIN_SH'(OFS_ESB):    esb_reg  <= req_wdata;
                WIN_SH'(OFS_NOTIFY): notify_q <= req_wdata;
                WIN_SH'(OFS_VECOFS): vecofs_q <= req_wdata;
                default: ;
            endcase
        end
    end

    // Response, source reset pulse and undecoded-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp <= '0; src_reset <= 1'b0; undec_err <= 1'b0;
        end else begin
            rsp.valid <= hit;
            rsp.bad   <= hit && !len_ok;
            rsp.data  <= !len_ok ? ALL_ONES : (req_write ? '0 : rd_val);
            src_reset <= wr_ok && (ofs == WIN_SH'(OFS_INTCTL)) && req_wdata[INTRST_BIT];
            undec_err <= wr_ok && !decoded;
        end
    end

    p_intrst_stored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_reset |-> intctl_q[INTRST_BIT]);
    p_bad_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp.bad |-> rsp.valid && rsp.data == ALL_ONES);
    p_undec_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        undec_err |-> rsp.valid && !rsp.bad);
endmodule

// File: rtl/bridge_esb_window.sv
// Event-page window tracker: opens on a 0->1 valid-flag transition of the
// event-page base register and closes on 1->0. Assumes one write per cycle.
module bridge_esb_window
    import bridge_regwin_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    output logic          en,
    output logic [AW-1:0] base
);
    // Map on rising flag, unmap on falling flag, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; base <= '0;
        end else if (wr) begin
            if (!old_val[EN_BIT] && new_val[EN_BIT]) begin
                en   <= 1'b1;
                base <= {new_val[AW-1:1], 1'b0};
            end else if (old_val[EN_BIT] && !new_val[EN_BIT]) begin
                en   <= 1'b0;
            end
        end
    end

    p_en_tracks_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> en == old_val[EN_BIT]);
    p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && en |-> $stable(base));
endmodule

// File: rtl/bridge_regwin.sv
// Top of the bridge register window controller: sideband BAR port, MMIO
// control registers and the event-page window tracker.
module bridge_regwin
    import bridge_regwin_pkg::*;
#(
    parameter int            AW       = 48,
    parameter int            SB_OFS_W = 8,
    parameter logic [DW-1:0] DEF_BASE = 64'h0000_0030_2030_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sb_valid,
    input  logic          sb_write,
    input  logic [7:0]    sb_addr,
    input  logic [3:0]    sb_len,
    input  logic [63:0]   sb_wdata,
    output logic          sb_rsp_valid,
    output logic          sb_rsp_bad,
    output logic [63:0]   sb_rsp_data,
    input  logic          mm_valid,
    input  logic          mm_write,
    input  logic [AW-1:0] mm_addr,
    input  logic [3:0]    mm_len,
    input  logic [63:0]   mm_wdata,
    output logic          mm_rsp_valid,
    output logic          mm_rsp_bad,
    output logic [63:0]   mm_rsp_data,
    output logic          win_en,
    output logic [AW-1:0] win_base,
    output logic          esb_en,
    output logic [AW-1:0] esb_base,
    output logic          src_reset,
    output logic          undec_err
);
    localparam int WIN_SH = 20;   // 1 MiB MMIO window

    rsp_t          sb_rsp, mm_rsp;
    logic [DW-1:0] bar, esb_reg, esb_prev;
    logic          esb_wr;
    logic          unused_bar_hi;

    assign unused_bar_hi = ^bar[DW-1:AW];
    assign win_en   = bar[EN_BIT];
    assign win_base = {bar[AW-1:1], 1'b0};

    bridge_sb_port #(.OFS_W(SB_OFS_W), .DEF_BASE(DEF_BASE), .BAR_OFS(0)) u_sb (
        .clk(clk), .rst_n(rst_n), .req_valid(sb_valid), .req_write(sb_write),
        .req_addr(sb_addr), .req_len(sb_len), .req_wdata(sb_wdata),
        .rsp(sb_rsp), .bar(bar));

    bridge_mmio_regs #(.AW(AW), .WIN_SH(WIN_SH)) u_mm (
        .clk(clk), .rst_n(rst_n), .bar_base(win_base), .bar_en(win_en),
        .req_valid(mm_valid), .req_write(mm_write), .req_addr(mm_addr),
        .req_len(mm_len), .req_wdata(mm_wdata), .rsp(mm_rsp),
        .undec_err(undec_err), .src_reset(src_reset),
        .esb_reg(esb_reg), .esb_wr(esb_wr));

    assign esb_prev = esb_reg;

    bridge_esb_window #(.AW(AW)) u_esb (
        .clk(clk), .rst_n(rst_n), .wr(esb_wr), .old_val(esb_prev),
        .new_val(mm_wdata), .en(esb_en), .base(esb_base));

    assign sb_rsp_valid = sb_rsp.valid;
    assign sb_rsp_bad   = sb_rsp.bad;
    assign sb_rsp_data  = sb_rsp.data;
    assign mm_rsp_valid = mm_rsp.valid;
    assign mm_rsp_bad   = mm_rsp.bad;
    assign mm_rsp_data  = mm_rsp.data;

    p_reset_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> win_en && win_base == DEF_BASE[AW-1:0] && !esb_en);
endmodule

// File: tb/sim_bridge_regwin.sv
// Scoreboard bench: driver tasks queue expected responses, a monitor pops them.
module sim_bridge_regwin;
    localparam int AW = 48;
    localparam logic [AW-1:0] DEF = 48'h0030_2030_0000;
    localparam logic [AW-1:0] NEWB = 48'h0012_3450_0000;
    localparam logic [63:0] ONES = '1;

    logic clk = 0, rst_n = 0;
    logic sb_valid = 0, sb_write = 0; logic [7:0] sb_addr = 0; logic [3:0] sb_len = 8;
    logic [63:0] sb_wdata = 0;
    logic mm_valid = 0, mm_write = 0; logic [AW-1:0] mm_addr = 0; logic [3:0] mm_len = 8;
    logic [63:0] mm_wdata = 0;
    logic sb_rsp_valid, sb_rsp_bad, mm_rsp_valid, mm_rsp_bad;
    logic [63:0] sb_rsp_data, mm_rsp_data;
    logic win_en, esb_en, src_reset, undec_err;
    logic [AW-1:0] win_base, esb_base;

    int checks = 0, fails = 0;
    logic [64:0] mm_q[$], sb_q[$];
    string mm_t[$], sb_t[$];

    always #5 clk = ~clk;

    bridge_regwin u0 (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every response with the queued expectation
    always @(negedge clk) if (rst_n) begin
        if (mm_rsp_valid) begin
            if (mm_q.size() == 0) chk("R4 unexpected mmio response", 64'(mm_rsp_data), 64'hDEAD);
            else begin
                logic [64:0] e; string t;
                e = mm_q.pop_front(); t = mm_t.pop_front();
                chk(t, {63'd0, mm_rsp_bad}, {63'd0, e[64]});
                chk(t, mm_rsp_data, e[63:0]);
            end
        end
        if (sb_rsp_valid) begin
            if (sb_q.size() == 0) chk("R3 unexpected sideband response", 64'(sb_rsp_data), 64'hDEAD);
            else begin
                logic [64:0] e; string t;
                e = sb_q.pop_front(); t = sb_t.pop_front();
                chk(t, {63'd0, sb_rsp_bad}, {63'd0, e[64]});
                chk(t, sb_rsp_data, e[63:0]);
            end
        end
    end

    task automatic mm(bit wr, logic [AW-1:0] a, logic [3:0] len, logic [63:0] d,
                      bit exp_rsp, bit ebad, logic [63:0] edata, string tag);
        if (exp_rsp) begin mm_q.push_back({ebad, edata}); mm_t.push_back(tag); end
        mm_valid = 1; mm_write = wr; mm_addr = a; mm_len = len; mm_wdata = d;
        @(posedge clk); #1;
        mm_valid = 0; mm_write = 0;
    endtask

    task automatic sb(bit wr, logic [7:0] a, logic [3:0] len, logic [63:0] d,
                      bit ebad, logic [63:0] edata, string tag);
        sb_q.push_back({ebad, edata}); sb_t.push_back(tag);
        sb_valid = 1; sb_write = wr; sb_addr = a; sb_len = len; sb_wdata = d;
        @(posedge clk); #1;
        sb_valid = 0; sb_write = 0;
    endtask

    task automatic idle(); @(posedge clk); #1; endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk); #1; rst_n = 1;
        idle();
        // R1 reset state
        chk("R1 win_en", 64'(win_en), 64'd1);
        chk("R1 win_base", 64'(win_base), 64'(DEF));
        chk("R1 esb_en", 64'(esb_en), 64'd0);
        mm(0, DEF + 'h58, 8, 0, 1, 0, 0, "R1 intctl reads zero");
        mm(0, DEF + 'h60, 8, 0, 1, 0, 0, "R1 esb reg reads zero");
        // R5 stored registers and no-effect offsets
        mm(1, DEF + 'h68, 8, 64'hA5A5_0000_1234_5678, 1, 0, 0, "R5 write notify");
        mm(0, DEF + 'h68, 8, 0, 1, 0, 64'hA5A5_0000_1234_5678, "R5 read notify");
        mm(1, DEF + 'h70, 8, 64'h0000_0040_0000_0000, 1, 0, 0, "R5 write vecofs");
        mm(0, DEF + 'h70, 8, 0, 1, 0, 64'h0000_0040_0000_0000, "R5 read vecofs");
        mm(1, DEF + 'h20, 8, 64'hFFFF, 1, 0, 0, "R5 write 0x20");
        mm(0, DEF + 'h20, 8, 0, 1, 0, 0, "R5 read 0x20 zero");
        mm(1, DEF + 'h28, 8, 64'h1, 1, 0, 0, "R5 write 0x28");
        chk("R5 0x28 write no error", 64'(undec_err), 64'd0);
        mm(0, DEF + 'h28, 8, 0, 1, 0, 0, "R5 read 0x28 zero");
        // R6 undecoded
        mm(0, DEF + 'h40, 8, 0, 1, 0, ONES, "R6 undecoded read ones");
        mm(1, DEF + 'h40, 8, 64'h55, 1, 0, 0, "R6 undecoded write");
        chk("R6 error pulse", 64'(undec_err), 64'd1);
        idle();
        chk("R6 error one cycle", 64'(undec_err), 64'd0);
        // R2 bad length
        mm(1, DEF + 'h68, 4, 64'h1111, 1, 1, ONES, "R2 short mmio write");
        mm(0, DEF + 'h68, 8, 0, 1, 0, 64'hA5A5_0000_1234_5678, "R2 notify unchanged");
        mm(0, DEF + 'h70, 2, 0, 1, 1, ONES, "R2 short mmio read");
        mm(1, DEF + 'h58, 4, 64'h4000_0000_0000_0000, 1, 1, ONES, "R2 short intctl write");
        chk("R2 no source reset", 64'(src_reset), 64'd0);
        // R7 source reset
        mm(1, DEF + 'h58, 8, 64'h4000_0000_0000_0003, 1, 0, 0, "R7 intctl reset write");
        chk("R7 src_reset pulse", 64'(src_reset), 64'd1);
        idle();
        chk("R7 src_reset one cycle", 64'(src_reset), 64'd0);
        mm(0, DEF + 'h58, 8, 0, 1, 0, 64'h4000_0000_0000_0003, "R7 value stored");
        mm(1, DEF + 'h58, 8, 64'h8000_0000_0000_0000, 1, 0, 0, "R7 write no reset bit");
        chk("R7 no pulse", 64'(src_reset), 64'd0);
        // R8 event-page window
        mm(1, DEF + 'h60, 8, 64'h0000_0030_2031_0001, 1, 0, 0, "R8 open esb");
        chk("R8 esb_en open", 64'(esb_en), 64'd1);
        chk("R8 esb_base", 64'(esb_base), 64'h0000_0030_2031_0000);
        mm(1, DEF + 'h60, 8, 64'h0000_0000_7770_0001, 1, 0, 0, "R8 rewrite valid");
        chk("R8 base kept", 64'(esb_base), 64'h0000_0030_2031_0000);
        chk("R8 still open", 64'(esb_en), 64'd1);
        mm(0, DEF + 'h60, 8, 0, 1, 0, 64'h0000_0000_7770_0001, "R8 stored value");
        mm(1, DEF + 'h60, 8, 64'h0000_0000_7770_0000, 1, 0, 0, "R8 close esb");
        chk("R8 esb closed", 64'(esb_en), 64'd0);
        mm(1, DEF + 'h60, 8, 64'h0000_0000_8880_0001, 1, 0, 0, "R8 reopen esb");
        chk("R8 new base", 64'(esb_base), 64'h0000_0000_8880_0000);
        // R3 sideband
        sb(0, 8'h00, 8, 0, 0, ONES, "R3 sideband read ones");
        sb(1, 8'h08, 8, 64'(NEWB) | 1, 0, 0, "R3 sideband other offset");
        chk("R3 base unchanged", 64'(win_base), 64'(DEF));
        sb(1, 8'h00, 4, 64'(NEWB) | 1, 1, ONES, "R2 short sideband write");
        chk("R2 base unchanged", 64'(win_base), 64'(DEF));
        sb(1, 8'h00, 8, 64'(NEWB) | 1, 0, 0, "R3 move window");
        chk("R3 new base", 64'(win_base), 64'(NEWB));
        chk("R3 enabled", 64'(win_en), 64'd1);
        // R4 window decode
        mm(0, NEWB + 'h68, 8, 0, 1, 0, 64'hA5A5_0000_1234_5678, "R4 read at new base");
        mm(0, DEF + 'h68, 8, 0, 0, 0, 0, "R4 old base ignored");
        mm(1, NEWB + 48'h10_0068, 8, 64'h9, 0, 0, 0, "R4 beyond 1MiB ignored");
        mm(0, NEWB + 'h68, 8, 0, 1, 0, 64'hA5A5_0000_1234_5678, "R4 outside write no effect");
        // R9 disable via BAR rewrite
        sb(1, 8'h00, 8, 64'(NEWB), 0, 0, "R9 disable window");
        chk("R9 win_en off", 64'(win_en), 64'd0);
        mm(1, NEWB + 'h68, 8, 64'h7, 0, 0, 0, "R9 disabled write ignored");
        sb(1, 8'h00, 8, 64'(NEWB) | 1, 0, 0, "R9 reenable");
        mm(0, NEWB + 'h68, 8, 0, 1, 0, 64'hA5A5_0000_1234_5678, "R9 value survived");
        repeat (3) idle();
        chk("scoreboard drained", 64'(mm_q.size() + sb_q.size()), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule